// File: doc/BRIEF.md
# Graphics Command Packet Framer

This block sits at the front of a drawing pipeline. It takes a stream of 32-bit command words over a valid/ready handshake and cuts the stream into whole command packets. The top byte of the first word of a packet is the opcode. A computed per-opcode lookup gives the number of parameter words that follow the opcode word. A packet is released only once all of its words have arrived. Ordinary packets are then offered as one parallel bundle on a downstream port with its own valid/ready pair.

While packets go through, the framer keeps a bank of eight environment shadow registers. Environment opcodes overwrite one of these registers. Textured primitives have their texture-page field copied into register 1. The low status bits are built from registers 1 and 6.

Two opcodes start an image transfer. These are not sent downstream. Instead, their position and size words are passed to a separate transfer engine with a one-cycle strobe. A one-cycle marker reports every packet whose opcode touches the frame buffer. A synchronous flush input drops a partly received packet.

Top module: `cmd_framer`

## Requirements
- R1: A packet is the opcode word plus N parameter words, where the opcode is bits 31:24 of the first word. When the last word is accepted, a non-transfer packet appears on `pkt_data` one cycle later, with word k at bits k*32+31:k*32, together with `pkt_valid` = 1 and `pkt_nwords` = N+1.
- R2: N is set by the opcode as follows.
  - Polygons 0x20–0x3F: bit 3 picks 4 vertices (set) or 3 (clear), and bit 2 marks textured. Flat shading (bit 4 clear) gives N = vertices × (1 + textured). Gouraud shading (bit 4 set) gives N = vertices × (2 + textured) − 1.
  - Lines 0x40–0x5F: N = 2 + bit 4 + bit 3.
  - Rectangles 0x60–0x7F: N = 1 + bit 2, plus one more when bits 4:3 are 00. The exception is 0x6C–0x6F, which give N = 0.
  - 0x80 gives 3. 0xA0 and 0xC0 give 2. Every other opcode gives 0.
- R3: A packet with opcode 0xE0–0xE7 stores its whole word into environment register (opcode & 7). This register is visible at `env_flat` bits i*32+31:i*32 one cycle after acceptance.
- R4: After reset, environment register i holds 0xE0+i in bits 31:24 and zero in bits 23:0. After reset no packet, transfer or dirty marker is pending.
- R5: When (opcode & 0xF4) == 0x24, bits 8:0 of packet word 4 replace bits 8:0 of environment register 1. When (opcode & 0xF4) == 0x34, packet word 5 is used instead. Bits 31:9 of register 1 are kept in both cases.
- R6: `status_bits[10:0]` equals environment register 1 bits 10:0. `status_bits[12:11]` equals environment register 6 bits 1:0.
- R7: Opcodes 0xA0 and 0xC0 produce no downstream packet. One cycle after their last word, `xfer_valid` pulses for one cycle with `xfer_pos` = word 1 and `xfer_size` = word 2. `xfer_read` is 1 for 0xC0 and 0 for 0xA0.
- R8: One cycle after the last word of any packet whose opcode lies in 0x02–0xBF, `dirty_pulse` is 1. It is 0 for all other packets.
- R9: A partly received packet waits, with no output, for its remaining words. While `pkt_valid` is 1 and `pkt_ready` is 0, `in_ready` is 0, and the held packet and the environment registers do not change.
- R10: While `cmd_flush` is 1, `in_ready` is 0. Flush drops any partial packet, so the next word starts a new packet. The environment registers are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_flush | input | 1 | Drop any partial packet |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Command word can be taken |
| pkt_valid | output | 1 | Complete packet offered downstream |
| pkt_ready | input | 1 | Downstream takes the packet |
| pkt_data | output | 384 | Packet words, word k at bits k*32 upward |
| pkt_nwords | output | 4 | Number of words in the packet |
| xfer_valid | output | 1 | One-cycle transfer start strobe |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| xfer_read | output | 1 | Transfer direction is read |
| dirty_pulse | output | 1 | Packet touched the frame buffer |
| env_flat | output | 256 | Eight environment registers, register i at bits i*32 upward |
| status_bits | output | 13 | Low status bits from environment registers |

## Verification
Every result of a packet is registered once. The downstream bundle, the transfer strobe, the dirty marker and the environment registers all change on the same clock edge that accepts the packet's last word. `status_bits` follows the registers with no further delay.

The bench drives its inputs on falling edges. A word counts as taken at the rising edge where `in_ready` was high. Every check is made at the falling edge right after the edge that took the last word, which is the only cycle in which the one-cycle strobes are visible. The stall and flush checks hold their stimulus for several cycles and sample at falling edges in between. This shows that nothing moved before the stall is released.

// File: rtl/cmdfrm_pkg.sv
package cmdfrm_pkg;

   localparam int OPC_W = 8;
   localparam int LEN_W = 4;

   typedef enum logic [1:0] {
      TEX_NONE = 2'd0,
      TEX_W4   = 2'd1,
      TEX_W5   = 2'd2
   } tex_sel_e;

   // parameter words following the opcode word
   function automatic logic [LEN_W-1:0] param_words(input logic [OPC_W-1:0] op);
      int r;
      int verts;
      int tex;
      r     = 0;
      verts = op[3] ? 4 : 3;
      tex   = op[2] ? 1 : 0;
      if (op[7:5] == 3'b001) begin
         if (op[4]) r = verts * (2 + tex) - 1;
         else       r = verts * (1 + tex);
      end else if (op[7:5] == 3'b010) begin
         r = 2 + (op[4] ? 1 : 0) + (op[3] ? 1 : 0);
      end else if (op[7:5] == 3'b011) begin
         if (op[4:2] == 3'b011) r = 0;
         else                   r = 1 + tex + ((op[4:3] == 2'b00) ? 1 : 0);
      end else if (op == 8'h80) begin
         r = 3;
      end else if (op == 8'hA0 || op == 8'hC0) begin
         r = 2;
      end
      return LEN_W'(r);
   endfunction

endpackage

// File: rtl/cmdfrm_decode.sv
module cmdfrm_decode
   import cmdfrm_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic [OPC_W-1:0] op,
   output logic [CNT_W-1:0] nparams,
   output logic             is_xfer,
   output logic             is_env,
   output logic             is_dirty,
   output tex_sel_e         tex_sel
);

   always_comb begin
      nparams  = CNT_W'(param_words(op));
      is_xfer  = (op == 8'hA0) || (op == 8'hC0);
      is_env   = (op[7:3] == 5'b11100);
      is_dirty = (op >= 8'h02) && (op <= 8'hBF);
      if ((op & 8'hF4) == 8'h24)      tex_sel = TEX_W4;
      else if ((op & 8'hF4) == 8'h34) tex_sel = TEX_W5;
      else                            tex_sel = TEX_NONE;
   end

endmodule

// File: rtl/cmdfrm_collect.sv
module cmdfrm_collect
   import cmdfrm_pkg::*;
#(
   parameter  int DATA_W    = 32,
   parameter  int MAX_WORDS = 12,
   localparam int CNT_W     = $clog2(MAX_WORDS),
   localparam int NW_W      = $clog2(MAX_WORDS + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic                        in_valid,
   input  logic [DATA_W-1:0]           in_data,
   output logic                        in_ready,
   output logic [OPC_W-1:0]            cur_op,
   input  logic [CNT_W-1:0]            nparams,
   input  logic                        is_xfer,
   input  logic                        pkt_ready,
   output logic                        pkt_valid,
   output logic [MAX_WORDS*DATA_W-1:0] pkt_data,
   output logic [NW_W-1:0]             pkt_nwords,
   output logic                        done,
   output logic [DATA_W-1:0]           word0,
   output logic [DATA_W-1:0]           word1,
   output logic [DATA_W-1:0]           word2,
   output logic [8:0]                  tex4,
   output logic [8:0]                  tex5
);

   logic [CNT_W-1:0]                   wcnt_q;
   logic [OPC_W-1:0]                   op_q;
   logic [MAX_WORDS-1:0][DATA_W-1:0]   buf_q;
   logic [MAX_WORDS-1:0][DATA_W-1:0]   asm_w;
   logic                               fire;
   logic                               first;

   assign in_ready = !(pkt_valid && !pkt_ready) && !flush;
   assign fire     = in_valid && in_ready;
   assign first    = (wcnt_q == '0);
   assign cur_op   = first ? in_data[DATA_W-1 -: OPC_W] : op_q;
   assign done     = fire && (wcnt_q == nparams);

   always_comb begin
      for (int k = 0; k < MAX_WORDS; k++)
         asm_w[k] = (wcnt_q == CNT_W'(k)) ? in_data : buf_q[k];
   end

   assign word0 = asm_w[0];
   assign word1 = asm_w[1];
   assign word2 = asm_w[2];
   assign tex4  = asm_w[4][8:0];
   assign tex5  = asm_w[5][8:0];

   always_ff @(posedge clk) begin
      for (int k = 0; k < MAX_WORDS; k++)
         if (fire && wcnt_q == CNT_W'(k)) buf_q[k] <= in_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcnt_q     <= '0;
         op_q       <= '0;
         pkt_valid  <= 1'b0;
         pkt_data   <= '0;
         pkt_nwords <= '0;
      end else begin
         if (flush) begin
            wcnt_q <= '0;
         end else if (fire) begin
            if (first) op_q <= in_data[DATA_W-1 -: OPC_W];
            wcnt_q <= done ? '0 : wcnt_q + 1'b1;
         end
         if (done && !is_xfer) begin
            pkt_valid  <= 1'b1;
            pkt_data   <= asm_w;
            pkt_nwords <= NW_W'(nparams) + NW_W'(1);
         end else if (pkt_ready) begin
            pkt_valid  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/cmdfrm_env.sv
module cmdfrm_env
   import cmdfrm_pkg::*;
#(
   parameter  int DATA_W        = 32,
   parameter  int ENV_REGS      = 8,
   parameter  bit SNOOP_TEXPAGE = 1'b1,
   localparam int SEL_W         = $clog2(ENV_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       done,
   input  logic                       is_env,
   input  logic [SEL_W-1:0]           env_sel,
   input  tex_sel_e                   tex_sel,
   input  logic [DATA_W-1:0]          word0,
   input  logic [8:0]                 tex4,
   input  logic [8:0]                 tex5,
   output logic [ENV_REGS*DATA_W-1:0] env_flat
);

   for (genvar i = 0; i < ENV_REGS; i++) begin : g_reg
      localparam logic [DATA_W-1:0] RST_VAL = {8'(8'hE0 + i), {(DATA_W-8){1'b0}}};
      logic             hit;
      logic [DATA_W-1:0] q;

      assign hit = done && is_env && (env_sel == SEL_W'(i));

      if (SNOOP_TEXPAGE && i == 1) begin : g_snoop
         always_ff @(posedge clk) begin
            if (!rst_n)                         q      <= RST_VAL;
            else if (hit)                       q      <= word0;
            else if (done && tex_sel == TEX_W4) q[8:0] <= tex4;
            else if (done && tex_sel == TEX_W5) q[8:0] <= tex5;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)   q <= RST_VAL;
            else if (hit) q <= word0;
         end
      end

      assign env_flat[i*DATA_W +: DATA_W] = q;
   end

endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
   import cmdfrm_pkg::*;
#(
   parameter  int DATA_W        = 32,
   parameter  int MAX_WORDS     = 12,
   parameter  int ENV_REGS      = 8,
   parameter  bit SNOOP_TEXPAGE = 1'b1,
   localparam int CNT_W         = $clog2(MAX_WORDS),
   localparam int NW_W          = $clog2(MAX_WORDS + 1),
   localparam int SEL_W         = $clog2(ENV_REGS),
   localparam int STAT_W        = 13
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_flush,
   input  logic                        in_valid,
   input  logic [DATA_W-1:0]           in_data,
   output logic                        in_ready,
   output logic                        pkt_valid,
   input  logic                        pkt_ready,
   output logic [MAX_WORDS*DATA_W-1:0] pkt_data,
   output logic [NW_W-1:0]             pkt_nwords,
   output logic                        xfer_valid,
   output logic [DATA_W-1:0]           xfer_pos,
   output logic [DATA_W-1:0]           xfer_size,
   output logic                        xfer_read,
   output logic                        dirty_pulse,
   output logic [ENV_REGS*DATA_W-1:0]  env_flat,
   output logic [STAT_W-1:0]           status_bits
);

   if (DATA_W != 32) begin : g_bad_width
      $error("cmd_framer: DATA_W must be 32");
   end
   if (MAX_WORDS < 12) begin : g_bad_depth
      $error("cmd_framer: MAX_WORDS must hold the longest packet (12)");
   end
   if (ENV_REGS != 8) begin : g_bad_env
      $error("cmd_framer: ENV_REGS must be 8");
   end

   logic [OPC_W-1:0]  cur_op;
   logic [CNT_W-1:0]  nparams;
   logic              is_xfer, is_env, is_dirty, done;
   tex_sel_e          tex_sel;
   logic [DATA_W-1:0] word0, word1, word2;
   logic [8:0]        tex4, tex5;

   cmdfrm_decode #(.CNT_W(CNT_W)) u_dec (
      .op(cur_op), .nparams(nparams), .is_xfer(is_xfer),
      .is_env(is_env), .is_dirty(is_dirty), .tex_sel(tex_sel)
   );

   cmdfrm_collect #(.DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS)) u_col (
      .clk(clk), .rst_n(rst_n), .flush(cmd_flush),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .cur_op(cur_op), .nparams(nparams), .is_xfer(is_xfer),
      .pkt_ready(pkt_ready), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
      .pkt_nwords(pkt_nwords), .done(done),
      .word0(word0), .word1(word1), .word2(word2), .tex4(tex4), .tex5(tex5)
   );

   cmdfrm_env #(.DATA_W(DATA_W), .ENV_REGS(ENV_REGS), .SNOOP_TEXPAGE(SNOOP_TEXPAGE)) u_env (
      .clk(clk), .rst_n(rst_n), .done(done), .is_env(is_env),
      .env_sel(cur_op[SEL_W-1:0]), .tex_sel(tex_sel), .word0(word0),
      .tex4(tex4), .tex5(tex5), .env_flat(env_flat)
   );

   assign status_bits = {env_flat[6*DATA_W +: 2], env_flat[DATA_W +: 11]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xfer_valid  <= 1'b0;
         xfer_pos    <= '0;
         xfer_size   <= '0;
         xfer_read   <= 1'b0;
         dirty_pulse <= 1'b0;
      end else begin
         xfer_valid  <= done && is_xfer;
         dirty_pulse <= done && is_dirty;
         if (done && is_xfer) begin
            xfer_pos  <= word1;
            xfer_size <= word2;
            xfer_read <= (cur_op == 8'hC0);
         end
      end
   end

endmodule

// File: rtl/cmdfrm_checker.sv
module cmdfrm_checker #(
   parameter int DATA_W    = 32,
   parameter int MAX_WORDS = 12,
   parameter int ENV_REGS  = 8,
   parameter int NW_W      = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cmd_flush,
   input logic                        in_ready,
   input logic                        pkt_valid,
   input logic                        pkt_ready,
   input logic [MAX_WORDS*DATA_W-1:0] pkt_data,
   input logic [NW_W-1:0]             pkt_nwords,
   input logic                        xfer_valid,
   input logic                        dirty_pulse,
   input logic [ENV_REGS*DATA_W-1:0]  env_flat
);

   p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !pkt_ready) |-> !in_ready);

   p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data) && $stable(pkt_nwords)
                                     && $stable(env_flat)));

   p_flush_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_flush |-> !in_ready);

   p_flush_env_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_flush |=> ($stable(env_flat) && !xfer_valid && !dirty_pulse));

   p_xfer_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |=> !xfer_valid);

   p_xfer_no_pkt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> !pkt_valid);

endmodule

bind cmd_framer cmdfrm_checker #(
   .DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS), .ENV_REGS(ENV_REGS), .NW_W(NW_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_flush(cmd_flush), .in_ready(in_ready),
   .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
   .pkt_nwords(pkt_nwords), .xfer_valid(xfer_valid), .dirty_pulse(dirty_pulse),
   .env_flat(env_flat)
);

// File: tb/tb_cmd_framer.sv
module tb_cmd_framer;

   logic         clk = 1'b0;
   logic         rst_n, cmd_flush, in_valid, pkt_ready;
   logic [31:0]  in_data;
   logic         in_ready, pkt_valid, xfer_valid, xfer_read, dirty_pulse;
   logic [383:0] pkt_data;
   logic [3:0]   pkt_nwords;
   logic [31:0]  xfer_pos, xfer_size;
   logic [255:0] env_flat;
   logic [12:0]  status_bits;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;
   logic [31:0] env_m [8];
   logic [31:0] pw [12];

   always #5 clk = ~clk;

   cmd_framer dut (
      .clk(clk), .rst_n(rst_n), .cmd_flush(cmd_flush), .in_valid(in_valid),
      .in_data(in_data), .in_ready(in_ready), .pkt_valid(pkt_valid),
      .pkt_ready(pkt_ready), .pkt_data(pkt_data), .pkt_nwords(pkt_nwords),
      .xfer_valid(xfer_valid), .xfer_pos(xfer_pos), .xfer_size(xfer_size),
      .xfer_read(xfer_read), .dirty_pulse(dirty_pulse), .env_flat(env_flat),
      .status_bits(status_bits)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic int exp_len(input logic [7:0] op);
      case (op) inside
         [8'h20:8'h23]: return 3;
         [8'h24:8'h27]: return 6;
         [8'h28:8'h2B]: return 4;
         [8'h2C:8'h2F]: return 8;
         [8'h30:8'h33]: return 5;
         [8'h34:8'h37]: return 8;
         [8'h38:8'h3B]: return 7;
         [8'h3C:8'h3F]: return 11;
         [8'h40:8'h47]: return 2;
         [8'h48:8'h57]: return 3;
         [8'h58:8'h5F]: return 4;
         [8'h60:8'h63]: return 2;
         [8'h64:8'h67]: return 3;
         [8'h68:8'h6B]: return 1;
         [8'h6C:8'h6F]: return 0;
         [8'h70:8'h73]: return 1;
         [8'h74:8'h77]: return 2;
         [8'h78:8'h7B]: return 1;
         [8'h7C:8'h7F]: return 2;
         8'h80:         return 3;
         8'hA0, 8'hC0:  return 2;
         default:       return 0;
      endcase
   endfunction

   task automatic push(input logic [31:0] w);
      in_valid = 1'b1;
      in_data  = w;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic check_env(input string req);
      for (int i = 0; i < 8; i++)
         check(env_flat[i*32 +: 32] == env_m[i], req, env_flat[i*32 +: 32], env_m[i]);
      check(status_bits == {env_m[6][1:0], env_m[1][10:0]}, "R6 status mirror",
            32'(status_bits), 32'({env_m[6][1:0], env_m[1][10:0]}));
   endtask

   // sends pw[0..n-1]; optional idle gap before word gap_at
   task automatic send_pkt(input int gap_at);
      logic [7:0] op;
      int n;
      op = pw[0][31:24];
      n  = exp_len(op) + 1;
      for (int i = 0; i < n; i++) begin
         if (i == gap_at) begin
            repeat (4) @(negedge clk);
            check(!pkt_valid, "R9 partial packet held", 32'(pkt_valid), 32'd0);
         end
         push(pw[i]);
      end
      if (op == 8'hA0 || op == 8'hC0) begin
         check(xfer_valid, "R7 transfer strobe", 32'(xfer_valid), 32'd1);
         check(xfer_pos == pw[1], "R7 transfer position", xfer_pos, pw[1]);
         check(xfer_size == pw[2], "R7 transfer size", xfer_size, pw[2]);
         check(xfer_read == (op == 8'hC0), "R7 read flag", 32'(xfer_read), 32'(op == 8'hC0));
         check(!pkt_valid, "R7 no raster packet", 32'(pkt_valid), 32'd0);
      end else begin
         check(pkt_valid, "R1 packet valid", 32'(pkt_valid), 32'd1);
         check(!xfer_valid, "R7 no strobe for ordinary packet", 32'(xfer_valid), 32'd0);
         check(pkt_nwords == 4'(n), "R2 packet length", 32'(pkt_nwords), 32'(n));
         for (int i = 0; i < n; i++)
            check(pkt_data[i*32 +: 32] == pw[i], "R1 packet word",
                  pkt_data[i*32 +: 32], pw[i]);
      end
      check(dirty_pulse == (op >= 8'h02 && op <= 8'hBF), "R8 dirty marker",
            32'(dirty_pulse), 32'(op >= 8'h02 && op <= 8'hBF));
      if (op[7:3] == 5'b11100) env_m[op[2:0]] = pw[0];
      if ((op & 8'hF4) == 8'h24)      env_m[1][8:0] = pw[4][8:0];
      else if ((op & 8'hF4) == 8'h34) env_m[1][8:0] = pw[5][8:0];
      check_env("R3 R5 environment registers");
   endtask

   task automatic fill(input logic [7:0] op);
      pw[0] = {op, 24'($urandom)};
      for (int i = 1; i < 12; i++) pw[i] = $urandom;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd5417));
      rst_n = 1'b0; cmd_flush = 1'b0; in_valid = 1'b0; in_data = '0; pkt_ready = 1'b1;
      for (int i = 0; i < 8; i++) env_m[i] = {8'(8'hE0 + i), 24'd0};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 reset state
      check(in_ready && !pkt_valid && !xfer_valid && !dirty_pulse, "R4 idle after reset",
            {in_ready, pkt_valid, xfer_valid, dirty_pulse}, 32'h8);
      check_env("R4 reset environment values");

      // R5 texture-page snoop, word 4 then word 5
      fill(8'h24); pw[4] = 32'hFFFF_FE55; send_pkt(-1);
      fill(8'h3E); pw[4] = 32'h0000_00AA; pw[5] = 32'h1234_51C3; send_pkt(-1);
      // R2 length corners
      fill(8'h6C); send_pkt(-1);
      fill(8'h6D); send_pkt(-1);
      fill(8'h3F); send_pkt(-1);
      fill(8'h80); send_pkt(-1);
      fill(8'h5A); send_pkt(-1);
      // R3/R6 environment writes
      fill(8'hE1); pw[0][23:0] = 24'h00_07FF; send_pkt(-1);
      fill(8'hE6); pw[0][23:0] = 24'h00_0002; send_pkt(-1);
      // R7 transfers
      fill(8'hA0); send_pkt(-1);
      fill(8'hC0); send_pkt(-1);
      // R9 partial packet waits
      fill(8'h28); send_pkt(2);

      // R9 downstream stall
      @(negedge clk);
      pkt_ready = 1'b0;
      pw[0] = 32'h0200_0000; send_pkt(-1);
      in_valid = 1'b1; in_data = 32'hE301_2345;
      #1;
      check(!in_ready, "R9 ready low while stalled", 32'(in_ready), 32'd0);
      repeat (3) @(negedge clk);
      check(pkt_valid && pkt_data[31:0] == 32'h0200_0000, "R9 held packet",
            pkt_data[31:0], 32'h0200_0000);
      check(env_flat[3*32 +: 32] == env_m[3], "R9 stalled word not taken",
            env_flat[3*32 +: 32], env_m[3]);
      pkt_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      env_m[3] = 32'hE301_2345;
      check(pkt_valid && pkt_data[31:0] == 32'hE301_2345 && pkt_nwords == 4'd1,
            "R9 word taken after release", pkt_data[31:0], 32'hE301_2345);
      check_env("R9 environment after release");

      // R10 flush of a partial textured packet
      fill(8'h24);
      for (int i = 0; i < 4; i++) push(pw[i]);
      cmd_flush = 1'b1;
      #1;
      check(!in_ready, "R10 ready low during flush", 32'(in_ready), 32'd0);
      @(negedge clk);
      cmd_flush = 1'b0;
      check(!pkt_valid && !dirty_pulse, "R10 nothing emitted", 32'(pkt_valid), 32'd0);
      check_env("R10 environment unchanged by flush");
      fill(8'hE6); pw[0][23:0] = 24'h00_0003; send_pkt(-1);

      // constrained random mix
      for (int k = 0; k < 400; k++) begin
         if ($urandom_range(0, 3) == 0) fill(8'hE0 | 8'($urandom_range(0, 7)));
         else if ($urandom_range(0, 9) == 0) fill(($urandom_range(0, 1) == 0) ? 8'hA0 : 8'hC0);
         else fill(8'($urandom_range(0, 255)));
         send_pkt(($urandom_range(0, 7) == 0) ? 1 : -1);
      end

      if (!ended) begin
         ended = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule